// File: doc/BRIEF.md
# Flag-Indexed Instruction Bundle Expander

This block sits between a compressed program store and the issue stage of a wide-issue core with a fixed set of functional-unit slots. A compressed instruction is a flag word holding one bit per slot; a set bit means that slot carries an operation in this instruction. The operations themselves live in one bank per slot, so an unused slot costs no storage. The block keeps an instruction counter that addresses the flag-word store, plus one read pointer per slot bank. A slot's pointer moves on only when that slot was used. From the flag word and the bank words it rebuilds a full-width bundle, and it writes an all-zero no-op into every unused slot.

The stores are synchronous memories outside the block. The block drives their addresses and takes their read data one cycle later. Each `advance` pulse requests the next instruction, and `advance` may be held high for back-to-back issue at one bundle per cycle. `restart` sends the program back to its first instruction. The block holds no program contents and does not interpret the operations.

Top module: `vliw_unpacker`

## Requirements
- R1: While `rst_n` is low and after its release, `bundle_valid` is 0, `bundle` is all zero, and `flag_addr` and every slot pointer on `bank_addr` are 0.
- R2: Each cycle with `advance` high and `restart` low drives the current instruction number on `flag_addr` and increments it by one at the next edge. With `advance` low the number holds.
- R3: The pointer of slot s on `bank_addr[s*AW +: AW]` increments by one only after an instruction whose flag bit s is 1. The flag word is the one returned on `flag_data` in the cycle after that instruction's advance. The pointer holds after a flag of 0 and in cycles with no instruction in flight.
- R4: An advance in cycle t gives `bundle_valid` high in cycle t+2, exactly once per advance. Back-to-back advances give consecutive valid bundles, and gaps between advances give the same gaps in valid.
- R5: In a valid bundle, a slot whose flag bit is 1 carries the word its bank returned. A slot whose flag bit is 0 carries the no-op encoding, which is all zeros.
- R6: Whenever `bundle_valid` is low, `bundle` is all zero.
- R7: `restart` takes priority over `advance`. After a cycle with `restart` high, `flag_addr` and all slot pointers are 0 and `bundle_valid` is low. Any instruction in flight during that cycle is discarded.
- R8: Slot s occupies bits `[s*OPW +: OPW]` of `bundle` and `bank_data` and flag bit s of `flag_data`. Slot pointers are packed the same way in `bank_addr` with width AW = clog2(DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Return to the first instruction and drop work in flight |
| advance | input | 1 | Request the next instruction |
| flag_addr | output | AW | Address into the flag-word store |
| flag_data | input | SLOTS | Flag word read one cycle after `flag_addr` |
| bank_addr | output | SLOTS*AW | Per-slot bank read pointers |
| bank_data | input | SLOTS*OPW | Per-slot bank words read one cycle after `bank_addr` |
| bundle | output | SLOTS*OPW | Expanded instruction bundle |
| bundle_valid | output | 1 | `bundle` holds an expanded instruction |

## Verification
The instruction counter on `flag_addr` and the slot pointers move at the edge after the cycle that causes the change. The expanded bundle appears two edges after its advance: one edge for the flag-word read and one for the bank read. The bench drives its inputs and samples outputs on the falling edge. A bundle sampled at falling edge k is therefore compared with the instruction advanced at falling edge k-2. Pointer and counter checks are made one falling edge after the stimulus. The expected bundles come from an uncompressed program table that the bench compresses into its own memory models.

// File: rtl/vliw_unpacker_pkg.sv
// Shared defaults and helpers for the instruction bundle expander.
package vliw_unpacker_pkg;
    localparam int unsigned DEF_SLOTS = 4;
    localparam int unsigned DEF_OPW   = 32;
    localparam int unsigned DEF_DEPTH = 64;

    // Address width needed for a store of the given depth (at least one bit).
    function automatic int unsigned addr_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/unp_fetch.sv
// Instruction counter stage.
// Drives the flag-store address and marks which cycles hold a flag word in flight.
// Assumes the flag store is a synchronous memory with one cycle of read latency.
module unp_fetch #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [AW-1:0] flag_addr,
    output logic          fetch_valid
);
    logic [AW-1:0] pc_q;

    // Instruction counter: cleared by reset or restart, stepped by advance.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pc_q <= '0;
        end else if (advance) begin
            pc_q <= pc_q + AW'(1);
        end
    end

    // Marks that the flag word for the issued address arrives next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
        end else begin
            fetch_valid <= advance && !restart;
        end
    end

    assign flag_addr = pc_q;
endmodule

// File: rtl/unp_slot_ptr.sv
// Per-slot bank read pointer.
// Steps once for every expanded instruction that uses this slot.
// Assumes the slot bank holds the operations of this slot in program order.
module unp_slot_ptr #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    // Pointer register: cleared by reset or restart, stepped by a used slot.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= ptr + AW'(1);
        end
    end
endmodule

// File: rtl/unp_slot_expand.sv
// Per-slot output field builder.
// Keeps this slot's use flag for one cycle, aligned with the bank read data.
// Passes the bank word through when the slot was used and inserts the no-op otherwise.
// Assumes the no-op encoding is all zeros.
module unp_slot_expand #(
    parameter int unsigned OPW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           use_in,
    input  logic [OPW-1:0] bank_word,
    output logic [OPW-1:0] field
);
    logic use_q;

    // Use flag aligned with the bank read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_q <= 1'b0;
        end else begin
            use_q <= use_in && !restart;
        end
    end

    // Field selection: the bank word or the no-op.
    always_comb begin
        field = use_q ? bank_word : '0;
    end
endmodule

// File: rtl/vliw_unpacker.sv
// Flag-indexed instruction bundle expander (top).
// Rebuilds fixed-width bundles from a flag-word store and one operation bank per slot.
// Both stores are external synchronous memories with one cycle of read latency.
// Latency from advance to bundle_valid is two cycles, and throughput is one bundle per cycle.
module vliw_unpacker
    import vliw_unpacker_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned OPW   = DEF_OPW,
    parameter int unsigned DEPTH = DEF_DEPTH
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   restart,
    input  logic                   advance,
    output logic [addr_width(DEPTH)-1:0]       flag_addr,
    input  logic [SLOTS-1:0]       flag_data,
    output logic [SLOTS*addr_width(DEPTH)-1:0] bank_addr,
    input  logic [SLOTS*OPW-1:0]   bank_data,
    output logic [SLOTS*OPW-1:0]   bundle,
    output logic                   bundle_valid
);
    localparam int unsigned AW = addr_width(DEPTH);

    logic fetch_valid;
    logic out_valid_q;

    unp_fetch #(.AW(AW)) fetch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .advance     (advance),
        .flag_addr   (flag_addr),
        .fetch_valid (fetch_valid)
    );

    // One pointer and one field builder per functional-unit slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic used;
        assign used = fetch_valid && flag_data[s];

        unp_slot_ptr #(.AW(AW)) ptr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .step    (used),
            .ptr     (bank_addr[s*AW +: AW])
        );

        unp_slot_expand #(.OPW(OPW)) exp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart   (restart),
            .use_in    (used),
            .bank_word (bank_data[s*OPW +: OPW]),
            .field     (bundle[s*OPW +: OPW])
        );
    end

    // Output valid: follows the fetch stage by one cycle unless restarted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= fetch_valid && !restart;
        end
    end

    assign bundle_valid = out_valid_q;
endmodule

// File: rtl/vliw_unpacker_chk.sv
// Property checker for the bundle expander, attached to every instance by bind.
module vliw_unpacker_chk #(
    parameter int unsigned SLOTS = 4,
    parameter int unsigned OPW   = 32,
    parameter int unsigned AW    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 restart,
    input logic                 advance,
    input logic [AW-1:0]        flag_addr,
    input logic [SLOTS-1:0]     flag_data,
    input logic [SLOTS*AW-1:0]  bank_addr,
    input logic [SLOTS*OPW-1:0] bank_data,
    input logic [SLOTS*OPW-1:0] bundle,
    input logic                 bundle_valid
);
    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> flag_addr == $past(flag_addr) + AW'(1));

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !restart) |=> $stable(flag_addr));

    // R4
    valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |-> ($past(advance && !restart, 2) && !$past(restart)));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bundle_valid |-> bundle == '0);

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (flag_addr == '0 && bank_addr == '0 && !bundle_valid));

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
        // R3
        ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && $past(rst_n && advance && !restart)) |=>
            bank_addr[s*AW +: AW] == $past(bank_addr[s*AW +: AW]) + AW'($past(flag_data[s])));

        // R3
        ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!restart && !$past(rst_n && advance && !restart)) |=> $stable(bank_addr[s*AW +: AW]));

        // R5
        field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bundle_valid |-> bundle[s*OPW +: OPW] ==
                ($past(flag_data[s]) ? bank_data[s*OPW +: OPW] : '0));
    end
endmodule

bind vliw_unpacker vliw_unpacker_chk #(.SLOTS(SLOTS), .OPW(OPW), .AW(AW)) chk_i (.*);

// File: tb/vliw_unpacker_tb_top.sv
`timescale 1ns/1ps
module vliw_unpacker_tb_top;
    localparam int SLOTS = 4;
    localparam int OPW   = 32;
    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int BW    = SLOTS*OPW;
    localparam int N     = 12;

    // Uncompressed reference program, slot 3 leftmost, slot 0 in bits [31:0]; zero = no-op.
    localparam logic [BW-1:0] PROG [N] = '{
        {32'h0000_0000, 32'hA300_0001, 32'h0000_0000, 32'h1100_0001},
        {32'hD400_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0000, 32'hB200_0001, 32'h1100_0002},
        {32'hD400_0002, 32'hA300_0002, 32'hB200_0002, 32'h1100_0003},
        {32'h0000_0000, 32'hA300_0003, 32'h0000_0000, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hD400_0003, 32'h0000_0000, 32'hB200_0003, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h1100_0004},
        {32'hD400_0004, 32'hA300_0004, 32'h0000_0000, 32'h1100_0005},
        {32'h0000_0000, 32'h0000_0000, 32'hB200_0004, 32'h0000_0000},
        {32'hD400_0005, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hD400_0006, 32'hA300_0005, 32'hB200_0005, 32'h1100_0006}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic advance = 1'b0;
    logic [AW-1:0]       flag_addr;
    logic [SLOTS-1:0]    flag_data;
    logic [SLOTS*AW-1:0] bank_addr;
    logic [BW-1:0]       bank_data;
    logic [BW-1:0]       bundle;
    logic                bundle_valid;

    logic [SLOTS-1:0] flag_mem [DEPTH];
    logic [OPW-1:0]   bank_mem [SLOTS][DEPTH];
    int used_cnt [SLOTS];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vliw_unpacker #(.SLOTS(SLOTS), .OPW(OPW), .DEPTH(DEPTH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (restart),
        .advance      (advance),
        .flag_addr    (flag_addr),
        .flag_data    (flag_data),
        .bank_addr    (bank_addr),
        .bank_data    (bank_data),
        .bundle       (bundle),
        .bundle_valid (bundle_valid)
    );

    // Synchronous memory models of the flag store and the slot banks.
    always @(posedge clk) begin
        flag_data <= flag_mem[flag_addr];
        for (int s = 0; s < SLOTS; s++)
            bank_data[s*OPW +: OPW] <= bank_mem[s][bank_addr[s*AW +: AW]];
    end

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample one cycle: expect either an idle output or a given bundle.
    task automatic expect_bundle(input bit want_valid, input logic [BW-1:0] exp, input string req);
        chk(bundle_valid == want_valid, {req, " valid"}, BW'(bundle_valid), BW'(want_valid));
        chk(bundle == (want_valid ? exp : '0), {req, " bundle"}, bundle, want_valid ? exp : '0);
    endtask

    task automatic expect_ptrs(input int pc, input bit use_counts, input string req);
        chk(flag_addr == AW'(pc), {req, " flag_addr"}, BW'(flag_addr), BW'(pc));
        for (int s = 0; s < SLOTS; s++) begin
            int e;
            e = use_counts ? used_cnt[s] : 0;
            chk(bank_addr[s*AW +: AW] == AW'(e), {req, " slot ptr"}, BW'(bank_addr[s*AW +: AW]), BW'(e));
        end
    endtask

    initial begin
        // Compress the reference program into the memory models.
        for (int s = 0; s < SLOTS; s++) used_cnt[s] = 0;
        for (int a = 0; a < DEPTH; a++) begin
            flag_mem[a] = '0;
            for (int s = 0; s < SLOTS; s++) bank_mem[s][a] = '0;
        end
        for (int i = 0; i < N; i++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (PROG[i][s*OPW +: OPW] != '0) begin
                    flag_mem[i][s] = 1'b1;
                    bank_mem[s][used_cnt[s]] = PROG[i][s*OPW +: OPW];
                    used_cnt[s]++;
                end
            end
        end

        // R1: reset state.
        repeat (3) @(negedge clk);
        expect_bundle(1'b0, '0, "R1");
        expect_ptrs(0, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        expect_bundle(1'b0, '0, "R1");

        // R4 R5 R8: back-to-back walk of the table, bundle due two edges after advance.
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            if (i >= 2) expect_bundle(1'b1, PROG[i-2], "R5");
            else        expect_bundle(1'b0, '0, "R4");
            advance = (i < N);
        end
        // R2 R3: counter and per-slot pointers after the whole program; R6 idle output.
        @(negedge clk);
        expect_ptrs(N, 1'b1, "R3");
        expect_bundle(1'b0, '0, "R6");

        // R7: restart clears counter and pointers.
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        expect_ptrs(0, 1'b0, "R7");

        // R4: advances with gaps give valid bundles with the same gaps.
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k >= 2 && (k % 2) == 0 && (k - 2) / 2 < 4) expect_bundle(1'b1, PROG[(k-2)/2], "R4");
            else                                           expect_bundle(1'b0, '0, "R4");
            advance = ((k % 2) == 0) && (k / 2 < 4);
        end
        // R2: counter held during gaps.
        chk(flag_addr == AW'(4), "R2 flag_addr", BW'(flag_addr), BW'(4));

        // R7: restart wins over a simultaneous advance.
        advance = 1'b1;
        restart = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        restart = 1'b0;
        expect_ptrs(0, 1'b0, "R7");

        // R7: instruction in flight during restart is dropped, then program restarts at 0.
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        expect_bundle(1'b0, '0, "R7");
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        expect_bundle(1'b0, '0, "R7");
        @(negedge clk);
        expect_bundle(1'b1, PROG[0], "R7");

        // R1: reset mid-run returns everything to zero.
        advance = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        advance = 1'b0;
        @(negedge clk);
        expect_bundle(1'b0, '0, "R1");
        expect_ptrs(0, 1'b0, "R1");
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule